// File: doc/BRIEF.md
# Fetch and Data Access Sequencer with Drain

This block is the control core of a simple in-order processor front end. It decides, cycle by cycle, when to request the next instruction from the instruction memory port. It hands each returned instruction to an external execute stage. When that stage reports a memory instruction, it issues the data access on the data memory port. It retires the instruction when the last response of that instruction arrives. Decode and execution live outside the block. They answer in the same cycle as the instruction response, through a small handshake that reports whether the instruction touches memory, whether it faulted, and which data address it uses.

Each memory port has a valid/ready request channel, a retry strobe and a response channel that carries a negative-acknowledge flag. A request that the port refuses is held inside the block until the retry strobe arrives, and then it is sent again unchanged. A response that comes back negatively acknowledged is sent again at once.

A level-sensitive drain request brings the sequencer to a quiet point where no memory access is in flight. Suspend, switch-out and activate controls move it between the idle, running and switched-out conditions.

Top module: `fetch_seq_top`

## Requirements
- R1: After reset the state is Idle (state code 0) and nothing is requested. A pulse on `activate_i` in Idle or SwitchedOut moves to Running (code 1), and the first instruction request, at the reset program counter, appears in the following cycle. The state codes are Idle 0, Running 1, IcacheRetry 2, IcacheWaitResponse 3, DcacheRetry 4, DcacheWaitResponse 5, SwitchedOut 6.
- R2: A request that is presented with ready low is kept, and the state moves to the matching retry state (2 or 4). In that state a request is presented only in a cycle where the retry strobe is high, and it carries the same address. Once it is accepted, the state moves to the matching wait state (3 or 5).
- R3: A response with the nack flag set, in a wait state, re-presents the held request in the same cycle. If it is accepted the state stays in the wait state; if it is refused the state goes to the retry state.
- R4: While `drain_req_i` is high in Idle, Running or SwitchedOut, `drained_o` is high from the next cycle and no request is presented. It falls the cycle after `drain_req_i` falls.
- R5: An instruction response that arrives while a drain is requested is discarded. It causes no execute pulse, the program counter and the retired count do not change, the state returns to Running and `drained_o` rises.
- R6: A data response that arrives while a drain is requested advances the program counter by the instruction size and retires the instruction. It then sets `drained_o` and starts no fetch while the drain stays requested.
- R7: In Running, a fetch with `fetch_fault_i` high presents no instruction request. The program counter becomes the fault vector and a new fetch follows.
- R8: A non-memory instruction completes in the cycle of its instruction response: the program counter advances by the instruction size and the state returns to Running. A memory instruction presents its data request in that same cycle and waits for the data response.
- R9: `suspend_i` in Running moves the state to Idle. Raised in a wait or retry state, it lets the current instruction finish and then moves to Idle instead of fetching.
- R10: The retired count rises by one only for an instruction that completes without an execute fault. An execute fault sends the program counter to the fault vector and retires nothing.
- R11: An instruction response outside state 3, or a data response outside state 5, changes no state and sets the sticky `proto_err_o` flag.
- R12: `switch_out_i` in Idle or Running moves the state to SwitchedOut, where no request is made until `activate_i` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| activate_i | input | 1 | Start running from Idle or SwitchedOut |
| suspend_i | input | 1 | Stop after the current instruction |
| switch_out_i | input | 1 | Move to SwitchedOut from Idle or Running |
| drain_req_i | input | 1 | Level drain request |
| drained_o | output | 1 | Quiescent indication |
| fetch_fault_i | input | 1 | Fetch address setup fault |
| if_req_valid_o | output | 1 | Instruction request valid |
| if_req_ready_i | input | 1 | Instruction request accepted |
| if_req_addr_o | output | AW | Instruction request address |
| if_retry_i | input | 1 | Instruction port retry strobe |
| if_rsp_valid_i | input | 1 | Instruction response valid |
| if_rsp_nack_i | input | 1 | Instruction response negatively acknowledged |
| d_req_valid_o | output | 1 | Data request valid |
| d_req_ready_i | input | 1 | Data request accepted |
| d_req_addr_o | output | AW | Data request address |
| d_retry_i | input | 1 | Data port retry strobe |
| d_rsp_valid_i | input | 1 | Data response valid |
| d_rsp_nack_i | input | 1 | Data response negatively acknowledged |
| exec_valid_o | output | 1 | Execute handshake strobe |
| exec_is_mem_i | input | 1 | Executed instruction needs a data access |
| exec_fault_i | input | 1 | Executed instruction faulted |
| exec_daddr_i | input | AW | Data address of the executed instruction |
| state_o | output | 3 | Current state code |
| pc_o | output | AW | Program counter |
| retired_o | output | CW | Retired instruction count |
| proto_err_o | output | 1 | Sticky unexpected-response flag |

## Verification
The hardest cases to reach are those where two protocol events overlap on one instruction. One is a negative acknowledge whose reissue is itself refused, which chains the wait and retry states. Another is a drain or suspend that arrives while a data access is in flight. The stimulus builds these step by step from a running state. It holds ready low across the cycle where a nack arrives. It raises the drain or suspend level in the middle of a wait state and only then delivers the response. A behavioural reference model in the bench follows every cycle, so each partial sequence is checked along the way and not only at its end.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_IRETRY = 3'd2,
    ST_IWAIT  = 3'd3,
    ST_DRETRY = 3'd4,
    ST_DWAIT  = 3'd5,
    ST_SWOUT  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/fetch_seq_req_port.sv
module fetch_seq_req_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send_new_i,
  input  logic [AW-1:0] new_addr_i,
  input  logic          reissue_i,
  input  logic          hold_i,
  input  logic          retry_i,
  input  logic          ready_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  output logic          accepted_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  assign req_valid_o = send_new_i | reissue_i | (hold_i & retry_i);
  assign req_addr_o  = send_new_i ? new_addr_i : addr_q;
  assign accepted_o  = req_valid_o & ready_i;
  assign addr_en     = send_new_i;
  assign addr_d      = new_addr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R2
  held_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> req_addr_o == $past(req_addr_o));
endmodule

// File: rtl/fetch_seq_retire_ctr.sv
module fetch_seq_retire_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d   = cnt_q + CW'(1);
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_d;
  end

  // R10
  retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != $past(cnt_q) |-> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/fetch_seq_top.sv
module fetch_seq_top
  import fetch_seq_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          CW         = 16,
  parameter logic [15:0] RESET_PC   = 16'h0100,
  parameter logic [15:0] FAULT_VEC  = 16'h0F00,
  parameter int          INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          activate_i,
  input  logic          suspend_i,
  input  logic          switch_out_i,
  input  logic          drain_req_i,
  output logic          drained_o,
  input  logic          fetch_fault_i,
  output logic          if_req_valid_o,
  input  logic          if_req_ready_i,
  output logic [AW-1:0] if_req_addr_o,
  input  logic          if_retry_i,
  input  logic          if_rsp_valid_i,
  input  logic          if_rsp_nack_i,
  output logic          d_req_valid_o,
  input  logic          d_req_ready_i,
  output logic [AW-1:0] d_req_addr_o,
  input  logic          d_retry_i,
  input  logic          d_rsp_valid_i,
  input  logic          d_rsp_nack_i,
  output logic          exec_valid_o,
  input  logic          exec_is_mem_i,
  input  logic          exec_fault_i,
  input  logic [AW-1:0] exec_daddr_i,
  output logic [2:0]    state_o,
  output logic [AW-1:0] pc_o,
  output logic [CW-1:0] retired_o,
  output logic          proto_err_o
);
  localparam logic [AW-1:0] PC_RST  = AW'(RESET_PC);
  localparam logic [AW-1:0] PC_FLT  = AW'(FAULT_VEC);
  localparam logic [AW-1:0] PC_STEP = AW'(INSN_BYTES);

  seq_state_e    st_q, st_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          drn_q, drn_d;
  logic          sus_q, sus_d;
  logic          perr_q, perr_d;

  logic i_new, i_ok, i_nack, i_acc;
  logic d_new, d_ok, d_nack, d_acc;
  logic exec_go, retire, quiet_st;
  seq_state_e    done_st;

  assign quiet_st = (st_q == ST_IDLE) | (st_q == ST_RUN) | (st_q == ST_SWOUT);
  assign i_new    = (st_q == ST_RUN) & ~drain_req_i & ~switch_out_i & ~suspend_i & ~fetch_fault_i;
  assign i_ok     = (st_q == ST_IWAIT) & if_rsp_valid_i & ~if_rsp_nack_i;
  assign i_nack   = (st_q == ST_IWAIT) & if_rsp_valid_i & if_rsp_nack_i;
  assign d_ok     = (st_q == ST_DWAIT) & d_rsp_valid_i & ~d_rsp_nack_i;
  assign d_nack   = (st_q == ST_DWAIT) & d_rsp_valid_i & d_rsp_nack_i;
  assign exec_go  = i_ok & ~drain_req_i;
  assign d_new    = exec_go & exec_is_mem_i & ~exec_fault_i;
  assign retire   = (exec_go & ~exec_is_mem_i & ~exec_fault_i) | d_ok;
  assign done_st  = (sus_q | suspend_i) ? ST_IDLE : ST_RUN;

  fetch_seq_req_port #(.AW(AW)) u_iport (
    .clk(clk), .rst_n(rst_n), .send_new_i(i_new), .new_addr_i(pc_q),
    .reissue_i(i_nack), .hold_i(st_q == ST_IRETRY), .retry_i(if_retry_i),
    .ready_i(if_req_ready_i), .req_valid_o(if_req_valid_o),
    .req_addr_o(if_req_addr_o), .accepted_o(i_acc));

  fetch_seq_req_port #(.AW(AW)) u_dport (
    .clk(clk), .rst_n(rst_n), .send_new_i(d_new), .new_addr_i(exec_daddr_i),
    .reissue_i(d_nack), .hold_i(st_q == ST_DRETRY), .retry_i(d_retry_i),
    .ready_i(d_req_ready_i), .req_valid_o(d_req_valid_o),
    .req_addr_o(d_req_addr_o), .accepted_o(d_acc));

  fetch_seq_retire_ctr #(.CW(CW)) u_ret (
    .clk(clk), .rst_n(rst_n), .inc_i(retire), .count_o(retired_o));

  always_comb begin
    st_d = st_q;
    pc_d = pc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (switch_out_i)    st_d = ST_SWOUT;
        else if (activate_i) st_d = ST_RUN;
      end
      ST_SWOUT: if (activate_i) st_d = ST_RUN;
      ST_RUN: begin
        if (switch_out_i)       st_d = ST_SWOUT;
        else if (suspend_i)     st_d = ST_IDLE;
        else if (drain_req_i)   st_d = ST_RUN;
        else if (fetch_fault_i) pc_d = PC_FLT;
        else                    st_d = i_acc ? ST_IWAIT : ST_IRETRY;
      end
      ST_IRETRY: if (i_acc) st_d = ST_IWAIT;
      ST_IWAIT: begin
        if (i_nack) st_d = i_acc ? ST_IWAIT : ST_IRETRY;
        else if (i_ok) begin
          if (drain_req_i)        st_d = done_st;
          else if (exec_fault_i) begin
            st_d = done_st;
            pc_d = PC_FLT;
          end else if (exec_is_mem_i) st_d = d_acc ? ST_DWAIT : ST_DRETRY;
          else begin
            st_d = done_st;
            pc_d = pc_q + PC_STEP;
          end
        end
      end
      ST_DRETRY: if (d_acc) st_d = ST_DWAIT;
      ST_DWAIT: begin
        if (d_nack) st_d = d_acc ? ST_DWAIT : ST_DRETRY;
        else if (d_ok) begin
          st_d = done_st;
          pc_d = pc_q + PC_STEP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    drn_d  = drain_req_i & (drn_q | quiet_st | i_ok | d_ok);
    sus_d  = (st_d == ST_IDLE) ? 1'b0 : (sus_q | (suspend_i & ~quiet_st));
    perr_d = perr_q | (if_rsp_valid_i & (st_q != ST_IWAIT))
                    | (d_rsp_valid_i & (st_q != ST_DWAIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= PC_RST;
      drn_q  <= 1'b0;
      sus_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      drn_q  <= drn_d;
      sus_q  <= sus_d;
      perr_q <= perr_d;
    end
  end

  assign exec_valid_o = exec_go;
  assign drained_o    = drn_q;
  assign state_o      = st_q;
  assign pc_o         = pc_q;
  assign proto_err_o  = perr_q;

  // R1
  ireq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_req_valid_o |-> (st_q == ST_RUN) || (st_q == ST_IRETRY) || (st_q == ST_IWAIT));
  // R4
  drained_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained_o && drain_req_i |-> !if_req_valid_o && !d_req_valid_o && quiet_st);
  // R5
  drain_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_ok && drain_req_i |=> $stable(pc_o) && $stable(retired_o) && drained_o);
  // R7
  fetch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && fetch_fault_i |-> !if_req_valid_o);
  // R10
  exec_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid_o && exec_fault_i |=> $stable(retired_o) && pc_o == PC_FLT);
  // R11
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_rsp_valid_i && (st_q != ST_IWAIT) |=> proto_err_o);
endmodule

// File: tb/sim_fetch_seq_top.sv
`timescale 1ns/1ps
module sim_fetch_seq_top;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int PCR = 'h100;
  localparam int FLT = 'hF00;
  localparam int STEP = 4;
  localparam int S_IDLE = 0, S_RUN = 1, S_IRT = 2, S_IWT = 3, S_DRT = 4, S_DWT = 5, S_SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic act, sus, sw, drn, ff, i_rdy, i_rt, i_rv, i_nk, d_rdy, d_rt, d_rv, d_nk, x_mem, x_flt;
  logic [AW-1:0] x_da;
  logic drained, ifv, dv, exv, perr;
  logic [AW-1:0] ifa, da, pc;
  logic [2:0] st;
  logic [CW-1:0] ret;

  fetch_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .activate_i(act), .suspend_i(sus), .switch_out_i(sw),
    .drain_req_i(drn), .drained_o(drained), .fetch_fault_i(ff),
    .if_req_valid_o(ifv), .if_req_ready_i(i_rdy), .if_req_addr_o(ifa),
    .if_retry_i(i_rt), .if_rsp_valid_i(i_rv), .if_rsp_nack_i(i_nk),
    .d_req_valid_o(dv), .d_req_ready_i(d_rdy), .d_req_addr_o(da),
    .d_retry_i(d_rt), .d_rsp_valid_i(d_rv), .d_rsp_nack_i(d_nk),
    .exec_valid_o(exv), .exec_is_mem_i(x_mem), .exec_fault_i(x_flt), .exec_daddr_i(x_da),
    .state_o(st), .pc_o(pc), .retired_o(ret), .proto_err_o(perr));

  int vecs = 0, errs = 0;
  int m_st, m_pc, m_ret, m_da;
  bit m_drn, m_sus, m_perr;
  bit e_ifv, e_dv, e_ex;
  int e_ifa, e_da;

  task automatic chk(string req, string what, int act_v, int exp_v);
    if (act_v != exp_v) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act_v, exp_v, $time);
    end
  endtask

  task automatic model_out();
    e_ifv = 0; e_dv = 0; e_ex = 0; e_ifa = m_pc; e_da = m_da;
    if (m_st == S_RUN) e_ifv = !drn && !sw && !sus && !ff;
    if (m_st == S_IRT) e_ifv = i_rt;
    if (m_st == S_IWT && i_rv && i_nk) e_ifv = 1;
    if (m_st == S_IWT && i_rv && !i_nk && !drn) begin
      e_ex = 1;
      if (x_mem && !x_flt) begin e_dv = 1; e_da = x_da; end
    end
    if (m_st == S_DRT) e_dv = d_rt;
    if (m_st == S_DWT && d_rv && d_nk) e_dv = 1;
  endtask

  task automatic model_upd();
    int nst = m_st;
    int fin = (m_sus || sus) ? S_IDLE : S_RUN;
    bit quiet = (m_st == S_IDLE || m_st == S_RUN || m_st == S_SW);
    bit done = 0;
    if ((i_rv && m_st != S_IWT) || (d_rv && m_st != S_DWT)) m_perr = 1;
    case (m_st)
      S_IDLE: if (sw) nst = S_SW; else if (act) nst = S_RUN;
      S_SW: if (act) nst = S_RUN;
      S_RUN: if (sw) nst = S_SW; else if (sus) nst = S_IDLE;
             else if (!drn) begin
               if (ff) m_pc = FLT; else nst = i_rdy ? S_IWT : S_IRT;
             end
      S_IRT: if (i_rt && i_rdy) nst = S_IWT;
      S_IWT: if (i_rv && i_nk) nst = i_rdy ? S_IWT : S_IRT;
             else if (i_rv) begin
               done = 1;
               if (drn) nst = fin;
               else if (x_flt) begin nst = fin; m_pc = FLT; end
               else if (x_mem) begin m_da = x_da; nst = d_rdy ? S_DWT : S_DRT; end
               else begin nst = fin; m_pc += STEP; m_ret++; end
             end
      S_DRT: if (d_rt && d_rdy) nst = S_DWT;
      S_DWT: if (d_rv && d_nk) nst = d_rdy ? S_DWT : S_DRT;
             else if (d_rv) begin done = 1; nst = fin; m_pc += STEP; m_ret++; end
      default: nst = S_IDLE;
    endcase
    m_drn = drn && (m_drn || quiet || done);
    if (nst == S_IDLE) m_sus = 0; else if (sus && !quiet) m_sus = 1;
    m_pc &= 'hFFFF;
    m_st = nst;
  endtask

  task automatic step();
    #1;
    model_out();
    vecs++;
    chk("R1", "state", int'(st), m_st);
    chk("R7", "pc", int'(pc), m_pc);
    chk("R10", "retired", int'(ret), m_ret);
    chk("R4", "drained", int'(drained), int'(m_drn));
    chk("R11", "proto_err", int'(perr), int'(m_perr));
    chk("R2", "if_valid", int'(ifv), int'(e_ifv));
    if (e_ifv) chk("R2", "if_addr", int'(ifa), e_ifa);
    chk("R8", "d_valid", int'(dv), int'(e_dv));
    if (e_dv) chk("R3", "d_addr", int'(da), e_da);
    chk("R5", "exec_valid", int'(exv), int'(e_ex));
    @(posedge clk);
    model_upd();
    @(negedge clk);
    {act, sus, sw, ff, i_rt, i_rv, i_nk, d_rt, d_rv, d_nk} = '0;
  endtask

  initial begin
    #20000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    {act, sus, sw, drn, ff, i_rt, i_rv, i_nk, d_rt, d_rv, d_nk, x_mem, x_flt} = '0;
    i_rdy = 1; d_rdy = 1; x_da = '0;
    m_st = S_IDLE; m_pc = PCR; m_ret = 0; m_da = 0; m_drn = 0; m_sus = 0; m_perr = 0;
    @(negedge clk); @(negedge clk);
    vecs++; chk("R1", "reset state", int'(st), S_IDLE);
    rst_n = 1;
    step(); step();                                   // R1 idle after reset
    act = 1; step(); step(); step();                  // R1 first fetch
    i_rv = 1; step();                                 // R8 non-memory completes
    i_rdy = 0; step(); step();                        // R2 refused fetch held
    i_rt = 1; step(); i_rdy = 1; i_rt = 1; step();    // R2 retry, then accepted
    i_rdy = 0; i_rv = 1; i_nk = 1; step();            // R3 nack reissue refused
    i_rdy = 1; i_rt = 1; step();
    i_rv = 1; i_nk = 1; step();                       // R3 nack reissue accepted
    x_mem = 1; x_da = 16'h2000; d_rdy = 0; i_rv = 1; step();   // R8 data request refused
    d_rt = 1; step(); d_rdy = 1; d_rt = 1; step();    // R2 data retry
    d_rv = 1; d_nk = 1; step();                       // R3 data nack
    d_rv = 1; step(); x_mem = 0;                      // R8 data completes
    ff = 1; step(); step();                           // R7 fetch fault
    x_flt = 1; i_rv = 1; step(); x_flt = 0;           // R10 execute fault
    drn = 1; step(); step(); step(); drn = 0; step(); // R4 drain in Running
    drn = 1; step(); i_rv = 1; step(); step();        // R5 drain discards instruction
    drn = 0; step();
    x_mem = 1; x_da = 16'h3000; i_rv = 1; step();
    drn = 1; step(); d_rv = 1; step(); step();        // R6 drain after data response
    drn = 0; x_mem = 0; step();
    sus = 1; step(); i_rv = 1; step(); step();        // R9 suspend while waiting
    act = 1; step(); sus = 1; step(); step();         // R9 suspend in Running
    act = 1; step(); sw = 1; step(); step();          // R12 switch out
    drn = 1; step(); step(); drn = 0; step();         // R4 drain in SwitchedOut
    act = 1; step(); step(); i_rv = 1; step();        // R12 activate again
    d_rv = 1; step(); i_rv = 1; step(); step();       // R11 stray responses
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule